// File: doc/BRIEF.md
# Real-Time Clock with Alarms

This block keeps time as a seconds count and a milliseconds count, advanced by a reference tick. The tick is a one-cycle strobe in the bus clock domain, one per period of a slow reference oscillator (32.768 kHz by default) and made by an upstream synchronizer. A fractional accumulator turns the reference rate into exact millisecond steps. Against the running time it checks two seconds-match alarms, one milliseconds-match alarm and a millisecond countdown. Each alarm sets a bit in a status register. A mask register selects which status bits drive one level interrupt.

Software reaches the block through a 32-bit register port with separate read and write strobes. The counters are copied to the bus side once per window of reference ticks, and a busy flag is high for the last tick period of each window. Writes that arrive while busy is high are held and applied afterwards. A read of the milliseconds register also latches the matching copied seconds into a shadow register, so software gets a coherent pair.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset every register, the busy flag, the interrupt and `rdata` are zero.
- R2: Each reference tick adds MS_HZ to an accumulator modulo REF_HZ. A wrap yields one millisecond step, so REF_HZ ticks give exactly MS_HZ steps. The milliseconds count runs 0 to MS_HZ-1. On the step after MS_HZ-1 it returns to 0 and seconds increments.
- R3: A tick counter runs modulo COPY_PERIOD. Busy (the output, and bit 0 at byte address 0x004) is 1 while the counter holds COPY_PERIOD-1. On the tick that ends that state, the pre-tick seconds and milliseconds are copied to the bus side.
- R4: `rdata` is loaded one cycle after `rd_en` with the addressed register. Seconds (0x008) and milliseconds (0x010) return the last copied values. Unmapped addresses return 0.
- R5: A read of 0x010 loads the shadow register (0x00C) with the copied seconds in the same access.
- R6: Seconds alarms at 0x014 and 0x018 set status bit 0 and bit 1 on the millisecond step where seconds increments to their value.
- R7: The milliseconds alarm at 0x01C (low 10 bits) sets status bit 2 on any millisecond step whose new count equals its value.
- R8: At 0x024, bit 31 enables the countdown and bits 27:0 hold the count. Each millisecond step decrements an enabled count. The step that takes it to zero (or finds it at 0 or 1) sets status bit 4 and clears the enable. Writing 0 stops it. A write takes priority over a decrement in the same cycle.
- R9: Status at 0x02C is write-one-to-clear. Bits written as 0 are unchanged, and a new event wins over a clear in the same cycle. Bit 3 always reads 0.
- R10: Mask at 0x028 holds bits 4:0. `irq` equals the OR of status AND mask. Status bits are set whatever the mask.
- R11: A write accepted while busy is held in a single slot, and a later write in the same window replaces it. The held write is applied in the first cycle that busy is low. Reads are never delayed.
- R12: A write to 0x008 loads the running seconds count and takes priority over a carry in the same cycle. It is visible to reads only after the next copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| busy | output | 1 | High during the copy window |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take for granted that `ref_tick` is a single-cycle strobe with at least one idle cycle between strobes, and that `rd_en` and `wr_en` are never high together. The bench issues a tick every third cycle and performs at most one access per cycle, so it stays within both. Alarm values are drawn near the running seconds and milliseconds so that matches actually occur. The reference rate is lowered so that several seconds roll over within the run.

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core #(
  parameter int REF_HZ      = 32768,
  parameter int MS_HZ       = 1000,
  parameter int COPY_PERIOD = 8,
  parameter int CNT_W       = 28,
  parameter int AW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          busy,
  output logic          irq
);
  localparam int ACC_W = $clog2(REF_HZ) + 1;
  localparam int PH_W  = (COPY_PERIOD > 1) ? $clog2(COPY_PERIOD) : 1;
  localparam int MS_W  = $clog2(MS_HZ);
  localparam int NIRQ  = 5;

  localparam logic [AW-1:0] A_BUSY = AW'(8'h04);
  localparam logic [AW-1:0] A_SEC  = AW'(8'h08);
  localparam logic [AW-1:0] A_SHD  = AW'(8'h0C);
  localparam logic [AW-1:0] A_MS   = AW'(8'h10);
  localparam logic [AW-1:0] A_SA0  = AW'(8'h14);
  localparam logic [AW-1:0] A_SA1  = AW'(8'h18);
  localparam logic [AW-1:0] A_MSA  = AW'(8'h1C);
  localparam logic [AW-1:0] A_CDN  = AW'(8'h24);
  localparam logic [AW-1:0] A_MSK  = AW'(8'h28);
  localparam logic [AW-1:0] A_STS  = AW'(8'h2C);

  logic [ACC_W-1:0] acc_q;
  logic [MS_W-1:0]  ms_q, ms_cp, msal_q;
  logic [31:0]      sec_q, sec_cp, shadow_q, sal0_q, sal1_q;
  logic [PH_W-1:0]  ph_q;
  logic             cdn_en;
  logic [CNT_W-1:0] cdn_cnt;
  logic [NIRQ-1:0]  mask_q, st_q, ev, clr;
  logic             pend_v;
  logic [AW-1:0]    pend_a;
  logic [31:0]      pend_d;
  logic             app_v;
  logic [AW-1:0]    app_a;
  logic [31:0]      app_d;
  logic [31:0]      rd_mux;

  wire [ACC_W-1:0] acc_sum = acc_q + ACC_W'(MS_HZ);
  wire             ms_tick = ref_tick && (acc_sum >= ACC_W'(REF_HZ));
  wire             ms_wrap = (ms_q == MS_W'(MS_HZ - 1));
  wire [MS_W-1:0]  ms_nx   = ms_wrap ? '0 : ms_q + MS_W'(1);
  wire [31:0]      sec_nx  = sec_q + 32'(ms_wrap);

  assign busy = (ph_q == PH_W'(COPY_PERIOD - 1));
  assign irq  = |(st_q & mask_q);

  always_comb begin
    app_v = 1'b0;
    app_a = addr;
    app_d = wdata;
    if (!busy) begin
      if (pend_v) begin
        app_v = 1'b1;
        app_a = pend_a;
        app_d = pend_d;
      end else if (wr_en) begin
        app_v = 1'b1;
      end
    end
  end

  wire wr_sec = app_v && (app_a == A_SEC);
  wire wr_cdn = app_v && (app_a == A_CDN);
  wire wr_sts = app_v && (app_a == A_STS);

  always_comb begin
    ev    = '0;
    ev[0] = ms_tick && ms_wrap && (sec_nx == sal0_q);
    ev[1] = ms_tick && ms_wrap && (sec_nx == sal1_q);
    ev[2] = ms_tick && (ms_nx == msal_q);
    ev[4] = ms_tick && cdn_en && (cdn_cnt <= CNT_W'(1));
    clr   = wr_sts ? app_d[NIRQ-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      ms_q  <= '0;
      sec_q <= '0;
      ph_q  <= '0;
    end else begin
      if (ref_tick) begin
        acc_q <= ms_tick ? acc_sum - ACC_W'(REF_HZ) : acc_sum;
        ph_q  <= busy ? '0 : ph_q + PH_W'(1);
      end
      if (ms_tick) begin
        ms_q  <= ms_nx;
        sec_q <= sec_nx;
      end
      if (wr_sec) sec_q <= app_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_cp   <= '0;
      ms_cp    <= '0;
      shadow_q <= '0;
    end else begin
      if (ref_tick && busy) begin
        sec_cp <= sec_q;
        ms_cp  <= ms_q;
      end
      if (rd_en && addr == A_MS) shadow_q <= sec_cp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      pend_d <= '0;
    end else if (busy) begin
      if (wr_en) begin
        pend_v <= 1'b1;
        pend_a <= addr;
        pend_d <= wdata;
      end
    end else if (pend_v) begin
      if (wr_en) begin
        pend_a <= addr;
        pend_d <= wdata;
      end else begin
        pend_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sal0_q  <= '0;
      sal1_q  <= '0;
      msal_q  <= '0;
      mask_q  <= '0;
      cdn_en  <= 1'b0;
      cdn_cnt <= '0;
      st_q    <= '0;
    end else begin
      if (app_v && app_a == A_SA0) sal0_q <= app_d;
      if (app_v && app_a == A_SA1) sal1_q <= app_d;
      if (app_v && app_a == A_MSA) msal_q <= app_d[MS_W-1:0];
      if (app_v && app_a == A_MSK) mask_q <= app_d[NIRQ-1:0];
      if (wr_cdn) begin
        cdn_en  <= app_d[31];
        cdn_cnt <= app_d[CNT_W-1:0];
      end else if (ms_tick && cdn_en) begin
        if (cdn_cnt <= CNT_W'(1)) begin
          cdn_cnt <= '0;
          cdn_en  <= 1'b0;
        end else begin
          cdn_cnt <= cdn_cnt - CNT_W'(1);
        end
      end
      st_q <= (st_q & ~clr) | ev;
    end
  end

  always_comb begin
    case (addr)
      A_BUSY:  rd_mux = {31'b0, busy};
      A_SEC:   rd_mux = sec_cp;
      A_SHD:   rd_mux = shadow_q;
      A_MS:    rd_mux = 32'(ms_cp);
      A_SA0:   rd_mux = sal0_q;
      A_SA1:   rd_mux = sal1_q;
      A_MSA:   rd_mux = 32'(msal_q);
      A_CDN:   rd_mux = {cdn_en, {(31-CNT_W){1'b0}}, cdn_cnt};
      A_MSK:   rd_mux = 32'(mask_q);
      A_STS:   rd_mux = 32'(st_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R2
  ms_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q < MS_W'(MS_HZ));

  // R2
  sec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_tick && ms_wrap && !wr_sec) |=> (ms_q == '0 && sec_q == $past(sec_q) + 32'd1));

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && busy) |=> !busy);

  // R5
  shadow_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_MS) |=> (shadow_q == $past(sec_cp)));

  // R8
  cdn_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[4]) |-> $past(cdn_en));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == A_MSK) |=> $stable(mask_q));
endmodule

// File: tb/rtc_alarm_core_tb.sv
`timescale 1ns/1ps
module rtc_alarm_core_tb;
  localparam int REF = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic busy, irq;

  always #2.5 clk = ~clk;

  rtc_alarm_core #(.REF_HZ(REF)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy), .irq(irq));

  int checks = 0, errors = 0, tcnt = 0;
  bit done = 0;

  int acc_m = 0, ms_m = 0, ph_m = 0, msb = 0;
  logic [31:0] sec_m = 0, secb = 0, shd = 0, alm0 = 0, alm1 = 0, rexp = 0;
  logic [9:0] msalm = 0;
  logic cdn_en = 0;
  logic [27:0] cdn_cnt = 0;
  logic [4:0] mask = 0, st = 0;
  bit pv = 0;
  logic [7:0] pa = 0;
  logic [31:0] pd = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] readval(logic [7:0] a);
    case (a)
      8'h04: return {31'b0, ph_m == 7};
      8'h08: return secb;
      8'h0C: return shd;
      8'h10: return 32'(msb);
      8'h14: return alm0;
      8'h18: return alm1;
      8'h1C: return {22'b0, msalm};
      8'h24: return {cdn_en, 3'b0, cdn_cnt};
      8'h28: return {27'b0, mask};
      8'h2C: return {27'b0, st};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(logic [7:0] a);
    case (a)
      8'h04: return "R3";
      8'h0C: return "R5";
      8'h14, 8'h18: return "R6";
      8'h1C: return "R7";
      8'h24: return "R8";
      8'h28: return "R10";
      8'h2C: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic model_step(bit tk, bit wr, bit rd, logic [7:0] a, logic [31:0] d);
    bit bz = (ph_m == 7);
    bit ap = 0;
    logic [7:0] aa = 0;
    logic [31:0] ad = 0;
    logic [4:0] ev = 0, clr = 0;
    if (rd) begin
      rexp = readval(a);
      if (a == 8'h10) shd = secb;
    end
    if (bz) begin
      if (wr) begin pv = 1; pa = a; pd = d; end
    end else if (pv) begin
      ap = 1; aa = pa; ad = pd;
      if (wr) begin pa = a; pd = d; end else pv = 0;
    end else if (wr) begin
      ap = 1; aa = a; ad = d;
    end
    if (tk) begin
      if (bz) begin secb = sec_m; msb = ms_m; end
      ph_m = (ph_m + 1) % 8;
      acc_m += 1000;
      if (acc_m >= REF) begin
        acc_m -= REF;
        if (ms_m == 999) begin
          ms_m = 0;
          sec_m = sec_m + 1;
          if (sec_m == alm0) ev[0] = 1;
          if (sec_m == alm1) ev[1] = 1;
        end else ms_m++;
        if (ms_m == int'(msalm)) ev[2] = 1;
        if (cdn_en) begin
          if (cdn_cnt <= 1) begin cdn_cnt = 0; cdn_en = 0; ev[4] = 1; end
          else cdn_cnt = cdn_cnt - 1;
        end
      end
    end
    if (ap) begin
      case (aa)
        8'h08: sec_m = ad;
        8'h14: alm0 = ad;
        8'h18: alm1 = ad;
        8'h1C: msalm = ad[9:0];
        8'h24: begin cdn_en = ad[31]; cdn_cnt = ad[27:0]; end
        8'h28: mask = ad[4:0];
        8'h2C: clr = ad[4:0];
        default: ;
      endcase
    end
    st = (st & ~clr) | ev;
  endtask

  task automatic cyc(bit wr, bit rd, logic [7:0] a, logic [31:0] d);
    bit tk = (tcnt % 3 == 0);
    tcnt++;
    ref_tick = tk; wr_en = wr; rd_en = rd; addr = a; wdata = d;
    @(posedge clk);
    model_step(tk, wr, rd, a, d);
    @(negedge clk);
    ref_tick = 0; wr_en = 0; rd_en = 0;
    chk(busy == (ph_m == 7), "R3", {31'b0, busy}, {31'b0, ph_m == 7});
    chk(irq == |(st & mask), "R10", {31'b0, irq}, {31'b0, |(st & mask)});
    if (rd) chk(rdata == rexp, req_of(a), rdata, rexp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 32'h0);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(1, 0, a, d);
  endtask

  task automatic rd(logic [7:0] a);
    cyc(0, 1, a, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finish_run();
  end

  initial begin
    logic [7:0] amap [11];
    amap = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h24, 8'h28, 8'h2C, 8'h3C};
    void'($urandom(32'h5EED_1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(rdata == 0, "R1", rdata, 0);
    chk(busy == 0, "R1", {31'b0, busy}, 0);
    chk(irq == 0, "R1", {31'b0, irq}, 0);
    foreach (amap[i]) begin
      rd(amap[i]);
      if (amap[i] != 8'h04) chk(rdata == 0, "R1", rdata, 0);
    end

    // R8: countdown of 3 ms fires bit 4 and drops its enable
    wr(8'h28, 32'h10);
    wr(8'h24, 32'h8000_0003);
    idle(200);
    rd(8'h2C);
    chk(rdata[4] == 1'b1, "R8", rdata, 32'h10);
    rd(8'h24);
    chk(rdata[31] == 1'b0, "R8", rdata, 0);
    // R10: masked bit drives irq
    chk(irq == 1'b1, "R10", {31'b0, irq}, 1);
    // R9: write of 0 keeps, write of 1 clears
    wr(8'h2C, 32'h0);
    idle(4);
    rd(8'h2C);
    chk(rdata[4] == 1'b1, "R9", rdata, 32'h10);
    wr(8'h2C, 32'h10);
    idle(4);
    rd(8'h2C);
    chk(rdata[4] == 1'b0, "R9", rdata, 0);
    // R8: writing 0 stops a running countdown
    wr(8'h24, 32'h8000_0100);
    idle(30);
    wr(8'h24, 32'h0);
    idle(1200);
    rd(8'h2C);
    chk(rdata[4] == 1'b0, "R8", rdata, 0);

    // R11: two writes inside one busy window, last one wins after busy drops
    while (ph_m != 7) idle(1);
    wr(8'h28, 32'h01);
    wr(8'h28, 32'h02);
    rd(8'h28);
    chk(rdata == 32'h10, "R11", rdata, 32'h10);
    idle(3);
    rd(8'h28);
    chk(rdata == 32'h02, "R11", rdata, 32'h02);

    // R12 / R6 / R2: load seconds, let two seconds roll over
    wr(8'h08, 32'h100);
    wr(8'h14, 32'h101);
    wr(8'h18, 32'h102);
    wr(8'h28, 32'h03);
    wr(8'h2C, 32'h1F);
    idle(13000);
    rd(8'h2C);
    chk(rdata[1:0] == 2'b11, "R6", rdata, 32'h3);
    chk(rdata[3] == 1'b0, "R9", rdata, 0);
    rd(8'h08);
    chk(rdata == secb, "R12", rdata, secb);
    chk(rdata >= 32'h102, "R12", rdata, 32'h102);
    // R5: shadow follows the copied seconds of the ms read
    rd(8'h10);
    rd(8'h0C);
    // R7: millisecond alarm ahead of the present count
    wr(8'h2C, 32'h1F);
    wr(8'h1C, 32'((ms_m + 20) % 1000));
    idle(200);
    rd(8'h2C);
    chk(rdata[2] == 1'b1, "R7", rdata, 32'h4);

    // random traffic
    for (int i = 0; i < 30000; i++) begin
      int r = int'($urandom % 100);
      if (r < 80) idle(1);
      else if (r < 88) rd(amap[$urandom % 11]);
      else begin
        case ($urandom % 8)
          0: wr(8'h14, sec_m + ($urandom % 2));
          1: wr(8'h18, sec_m + ($urandom % 2));
          2: wr(8'h1C, 32'((ms_m + int'($urandom % 40)) % 1000));
          3: wr(8'h24, {1'b1, 3'b0, 28'($urandom % 60)});
          4: wr(8'h28, $urandom);
          5: wr(8'h2C, $urandom);
          6: wr(8'h08, $urandom % 1000);
          default: rd(8'h10);
        endcase
      end
    end
    finish_run();
  end
endmodule